// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block turns the system clock into the timing that an SPI frame engine needs. A baud path produces the serial clock level together with one-cycle strobes that mark its rising and falling edges. Two delay paths each count out a chip-select interval and raise a one-cycle done pulse when it ends. One delay path covers select-to-first-edge set-up and the other covers last-edge-to-deselect hold.

No divisor is a plain binary count. Each one is the product of a small odd-ish prescaler picked by a 2-bit index and a scaler picked by a 4-bit index. Each path keeps its own pair of indices. The frame engine drives the indices from the attribute set it has selected and issues start requests. The block captures the indices on each request, so the engine can change them freely between requests.

Top module: `spi_tmgen`

## Requirements
- R1: Out of reset, `sck_level`, `sck_rise`, `sck_fall`, `lead_done` and `trail_done` are all low.
- R2: The baud prescaler index selects a factor from {0:2, 1:3, 2:5, 3:7}.
- R3: The baud scaler index s selects 2, 4 or 6 for s = 0, 1, 2, and 2^s for s = 3 to 15 (8 up to 32768).
- R4: Let D be the baud prescaler factor times the baud scaler factor. After a frame start, the clock stays low for D - floor(D/2) enabled cycles and then high for floor(D/2) enabled cycles, repeating with period D. `sck_rise` is high exactly in the first cycle that the level is high, and `sck_fall` is high exactly in the first cycle that it is low again.
- R5: A cycle with `frame_start` high forces the clock low, restarts the phase count and captures the baud indices. This holds even in the middle of a high phase. Baud index changes with no frame start have no effect on the timing.
- R6: While `sck_en` is low (and there is no frame start), the phase count and the clock level hold and no strobe is issued.
- R7: A delay prescaler index selects a factor from {0:1, 1:3, 2:5, 3:7}, and a delay scaler index n selects 2^(n+1).
- R8: A start request on a delay path, sampled at clock edge e, makes that path's done output high in the cycle following edge e + N, where N is that path's prescaler factor times its scaler factor. The two delay paths run independently, each with its own captured index pair, and index changes after the request have no effect.
- R9: Each done pulse lasts exactly one cycle. A new start request on a path that is still counting restarts the count, and only the restarted count produces a done pulse.
- R10: `sck_rise` and `sck_fall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Reload baud path, capture baud indices |
| sck_en | input | 1 | Baud phase counting enable |
| baud_pre_idx | input | 2 | Baud prescaler index |
| baud_scl_idx | input | 4 | Baud scaler index |
| sck_level | output | 1 | Serial clock level (idle low) |
| sck_rise | output | 1 | Rising-edge strobe |
| sck_fall | output | 1 | Falling-edge strobe |
| lead_start | input | 1 | Start set-up delay |
| lead_pre_idx | input | 2 | Set-up delay prescaler index |
| lead_scl_idx | input | 4 | Set-up delay scaler index |
| lead_done | output | 1 | Set-up delay finished pulse |
| trail_start | input | 1 | Start hold delay |
| trail_pre_idx | input | 2 | Hold delay prescaler index |
| trail_scl_idx | input | 4 | Hold delay scaler index |
| trail_done | output | 1 | Hold delay finished pulse |

## Verification
A wrong captured divisor or table entry moves the first rising strobe away from D - floor(D/2) cycles after the frame start, so it shows within one half period. A stuck phase counter shows as a missing strobe or as a level that disagrees with the cycle-by-cycle expected waveform. A delay count that is off by one, or one that is not reloaded on a restart, shows up at the done pulse position measured against the start. That is at most N + 1 cycles after the request. A double or stretched done pulse shows in the cycle after it.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

    localparam int PRE_W  = 2;
    localparam int SCL_W  = 4;
    // 7 * 2^(2^SCL_W - 1) fits in 2^SCL_W + 2 bits
    localparam int BAUD_W = (2 ** SCL_W) + 2;
    // 7 * 2^(2^SCL_W) fits in 2^SCL_W + 3 bits
    localparam int DLY_W  = (2 ** SCL_W) + 3;
    localparam int N_DLY  = 2;

    typedef struct packed {
        logic [BAUD_W-1:0] div;
        logic [BAUD_W-1:0] cnt;
        logic              sck;
        logic              rise;
        logic              fall;
    } baud_st_t;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             busy;
        logic             done;
    } dly_st_t;

    function automatic logic [BAUD_W-1:0] baud_divisor(
        input logic [PRE_W-1:0] p,
        input logic [SCL_W-1:0] s
    );
        logic [BAUD_W-1:0] pv;
        logic [BAUD_W-1:0] sv;
        case (p)
            2'd0:    pv = BAUD_W'(2);
            2'd1:    pv = BAUD_W'(3);
            2'd2:    pv = BAUD_W'(5);
            default: pv = BAUD_W'(7);
        endcase
        if (s < SCL_W'(3)) sv = BAUD_W'({s, 1'b0}) + BAUD_W'(2);
        else               sv = BAUD_W'(1) << s;
        return pv * sv;
    endfunction

    function automatic logic [DLY_W-1:0] delay_count(
        input logic [PRE_W-1:0] p,
        input logic [SCL_W-1:0] s
    );
        logic [DLY_W-1:0] pv;
        logic [SCL_W:0]   sh;
        case (p)
            2'd0:    pv = DLY_W'(1);
            2'd1:    pv = DLY_W'(3);
            2'd2:    pv = DLY_W'(5);
            default: pv = DLY_W'(7);
        endcase
        sh = {1'b0, s} + (SCL_W+1)'(1);
        return pv * (DLY_W'(1) << sh);
    endfunction

endpackage

// File: rtl/spi_tm_baud.sv
module spi_tm_baud
    import spi_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             sck_en,
    input  logic [PRE_W-1:0] pre_idx,
    input  logic [SCL_W-1:0] scl_idx,
    output logic             sck_level,
    output logic             sck_rise,
    output logic             sck_fall
);

    baud_st_t st_d, st_q;
    logic [BAUD_W-1:0] half_hi;
    logic [BAUD_W-1:0] phase_len;

    always_comb begin
        half_hi   = st_q.div >> 1;
        phase_len = st_q.sck ? half_hi : (st_q.div - half_hi);
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (frame_start) begin
            st_d.div = baud_divisor(pre_idx, scl_idx);
            st_d.cnt = '0;
            st_d.sck = 1'b0;
        end else if (sck_en) begin
            if (st_q.cnt == phase_len - BAUD_W'(1)) begin
                st_d.cnt  = '0;
                st_d.sck  = ~st_q.sck;
                st_d.rise = ~st_q.sck;
                st_d.fall = st_q.sck;
            end else begin
                st_d.cnt = st_q.cnt + BAUD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.div  <= baud_divisor('0, '0);
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_level = st_q.sck;
    assign sck_rise  = st_q.rise;
    assign sck_fall  = st_q.fall;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sck_rise, sck_fall}));

    // R4
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |-> (sck_level && !$past(sck_level)));

    // R5
    reload_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!sck_level && !sck_rise && !sck_fall));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_en && !frame_start) |=> ($stable(sck_level) && !sck_rise && !sck_fall));

endmodule

// File: rtl/spi_tm_delay.sv
module spi_tm_delay
    import spi_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PRE_W-1:0] pre_idx,
    input  logic [SCL_W-1:0] scl_idx,
    output logic             done
);

    dly_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.cnt  = delay_count(pre_idx, scl_idx) - DLY_W'(1);
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - DLY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.busy && !done));

    // R9
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !st_q.busy);

endmodule

// File: rtl/spi_tmgen.sv
module spi_tmgen
    import spi_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             sck_en,
    input  logic [PRE_W-1:0] baud_pre_idx,
    input  logic [SCL_W-1:0] baud_scl_idx,
    output logic             sck_level,
    output logic             sck_rise,
    output logic             sck_fall,
    input  logic             lead_start,
    input  logic [PRE_W-1:0] lead_pre_idx,
    input  logic [SCL_W-1:0] lead_scl_idx,
    output logic             lead_done,
    input  logic             trail_start,
    input  logic [PRE_W-1:0] trail_pre_idx,
    input  logic [SCL_W-1:0] trail_scl_idx,
    output logic             trail_done
);

    logic [N_DLY-1:0]            d_start;
    logic [N_DLY-1:0][PRE_W-1:0] d_pre;
    logic [N_DLY-1:0][SCL_W-1:0] d_scl;
    logic [N_DLY-1:0]            d_done;

    assign d_start = {trail_start, lead_start};
    assign d_pre   = {trail_pre_idx, lead_pre_idx};
    assign d_scl   = {trail_scl_idx, lead_scl_idx};
    assign lead_done  = d_done[0];
    assign trail_done = d_done[1];

    spi_tm_baud u_baud (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .sck_en      (sck_en),
        .pre_idx     (baud_pre_idx),
        .scl_idx     (baud_scl_idx),
        .sck_level   (sck_level),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall)
    );

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        spi_tm_delay u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (d_start[g]),
            .pre_idx (d_pre[g]),
            .scl_idx (d_scl[g]),
            .done    (d_done[g])
        );
    end

endmodule

// File: tb/spi_tmgen_bench.sv
module spi_tmgen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, sck_en = 1'b0;
    logic [1:0] baud_pre_idx = '0, lead_pre_idx = '0, trail_pre_idx = '0;
    logic [3:0] baud_scl_idx = '0, lead_scl_idx = '0, trail_scl_idx = '0;
    logic lead_start = 1'b0, trail_start = 1'b0;
    logic sck_level, sck_rise, sck_fall, lead_done, trail_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_tmgen u_spi_tmgen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sck_en(sck_en),
        .baud_pre_idx(baud_pre_idx), .baud_scl_idx(baud_scl_idx),
        .sck_level(sck_level), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .lead_start(lead_start), .lead_pre_idx(lead_pre_idx),
        .lead_scl_idx(lead_scl_idx), .lead_done(lead_done),
        .trail_start(trail_start), .trail_pre_idx(trail_pre_idx),
        .trail_scl_idx(trail_scl_idx), .trail_done(trail_done)
    );

    function automatic int bdiv(input int p, input int s);
        int pt[4] = '{2, 3, 5, 7};
        int sv;
        sv = (s < 3) ? 2 * (s + 1) : (1 << s);
        return pt[p] * sv;
    endfunction

    function automatic int ddiv(input int p, input int s);
        int pt[4] = '{1, 3, 5, 7};
        return pt[p] * (1 << (s + 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Frame start, optional sck_en gap of fl cycles from enabled edge fa
    task automatic run_baud(input int p, input int s, input int fa, input int fl);
        int d, h, l, r1, f1, r2, nr, nf, bad, lim;
        logic ex;
        d = bdiv(p, s); h = d / 2; l = d - h;
        @(negedge clk);
        frame_start = 1'b1; baud_pre_idx = 2'(p); baud_scl_idx = 4'(s); sck_en = 1'b0;
        @(posedge clk); @(negedge clk);
        frame_start = 1'b0;
        baud_pre_idx = 2'($urandom); baud_scl_idx = 4'($urandom);
        chk(!sck_level && !sck_rise && !sck_fall, "R5 low after reload", int'(sck_level), 0);
        r1 = -1; f1 = -1; r2 = -1; nr = 0; nf = 0; bad = 0;
        lim = d + l + fl + 1;
        for (int k = 1; k <= lim; k++) begin
            sck_en = !(fl > 0 && k >= fa && k < fa + fl);
            @(posedge clk); @(negedge clk);
            if (sck_rise) begin nr++; if (nr == 1) r1 = k; else if (nr == 2) r2 = k; end
            if (sck_fall) begin nf++; if (nf == 1) f1 = k; end
            ex = ((k >= l + fl) && (k < d + fl)) || (k >= d + l + fl);
            if (sck_level !== ex) bad++;
        end
        sck_en = 1'b0;
        chk(r1 == l + fl, "R4 first rise", r1, l + fl);
        chk(f1 == d + fl, "R4 first fall", f1, d + fl);
        chk(r2 == d + l + fl, "R2 R3 period", r2, d + l + fl);
        chk(nr == 2 && nf == 1, "R10 strobe count", nr * 10 + nf, 21);
        chk(bad == 0, fl > 0 ? "R6 level during gap" : "R4 level", bad, 0);
    endtask

    task automatic run_dly(input bit [1:0] m, input int p0, input int s0,
                           input int p1, input int s1);
        int n0, n1, lim, k0, k1, c0, c1;
        n0 = ddiv(p0, s0); n1 = ddiv(p1, s1);
        lim = ((n0 > n1) ? n0 : n1) + 3;
        @(negedge clk);
        lead_start = m[0]; trail_start = m[1];
        lead_pre_idx = 2'(p0); lead_scl_idx = 4'(s0);
        trail_pre_idx = 2'(p1); trail_scl_idx = 4'(s1);
        @(posedge clk); @(negedge clk);
        lead_start = 1'b0; trail_start = 1'b0;
        lead_pre_idx = 2'($urandom); lead_scl_idx = 4'($urandom);
        trail_pre_idx = 2'($urandom); trail_scl_idx = 4'($urandom);
        k0 = -1; k1 = -1; c0 = 0; c1 = 0;
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk); @(negedge clk);
            if (lead_done)  begin c0++; if (c0 == 1) k0 = k; end
            if (trail_done) begin c1++; if (c1 == 1) k1 = k; end
        end
        if (m[0]) chk(k0 == n0, "R7 R8 lead delay", k0, n0);
        if (m[1]) chk(k1 == n1, "R7 R8 trail delay", k1, n1);
        chk(c0 == int'(m[0]), "R9 lead pulses", c0, int'(m[0]));
        chk(c1 == int'(m[1]), "R9 trail pulses", c1, int'(m[1]));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!sck_level && !sck_rise && !sck_fall, "R1 sck in reset", int'(sck_level), 0);
        chk(!lead_done && !trail_done, "R1 done in reset", int'(lead_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sck_level && !sck_rise && !sck_fall && !lead_done && !trail_done,
            "R1 after reset", int'(sck_level), 0);

        // directed baud corners
        run_baud(0, 0, 0, 0);
        run_baud(3, 2, 0, 0);
        run_baud(1, 4, 0, 0);
        run_baud(2, 9, 0, 0);
        run_baud(3, 1, 5, 10);   // R6 gap before first rise (L = 14)
        // R5 reload in the middle of a high phase
        @(negedge clk);
        frame_start = 1'b1; baud_pre_idx = 2'd0; baud_scl_idx = 4'd0;
        @(negedge clk);
        frame_start = 1'b0; sck_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(sck_level == 1'b1, "R5 high before reload", int'(sck_level), 1);
        run_baud(1, 3, 0, 0);

        for (int t = 0; t < 12; t++)
            run_baud(int'($urandom % 4), int'($urandom % 7), 0, 0);

        // delays
        run_dly(2'b01, 0, 0, 0, 0);
        run_dly(2'b10, 3, 3, 0, 0);
        run_dly(2'b11, 1, 2, 2, 4);
        run_dly(2'b11, 3, 5, 0, 1);
        for (int t = 0; t < 12; t++)
            run_dly(2'($urandom % 3 + 1), int'($urandom % 4), int'($urandom % 7),
                    int'($urandom % 4), int'($urandom % 7));

        // R9 restart while counting: 3*8 = 24, second start at edge 6
        begin
            int kd, cd;
            kd = -1; cd = 0;
            @(negedge clk);
            lead_start = 1'b1; lead_pre_idx = 2'd1; lead_scl_idx = 4'd2;
            @(posedge clk); @(negedge clk);
            lead_start = 1'b0;
            for (int k = 1; k <= 36; k++) begin
                if (k == 6) lead_start = 1'b1;
                @(posedge clk); @(negedge clk);
                lead_start = 1'b0;
                if (lead_done) begin cd++; if (cd == 1) kd = k; end
            end
            chk(kd == 30, "R9 restart position", kd, 30);
            chk(cd == 1, "R9 restart single pulse", cd, 1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule